// File: doc/BRIEF.md
# Super I/O configuration port

This block is the configuration front end of a legacy peripheral controller. A host reaches it through two adjacent I/O addresses: an index port at the base address and a data port at base+1. The host first selects a register by writing its number to the index port, then reads or writes that register through the data port.

The port stays locked after reset. It opens only after the host writes a four-byte key to the index port. The last byte of the key depends on which of the two legal base addresses the instance uses. Once open, the host can read a two-byte chip identifier and pick a logical device. It can also program a global flash-window control register and, in the flash logical device, a 16-bit base address for the serial-flash controller. A write to the exit register locks the port again. The control bits and the base address are driven out as plain outputs for the logic they steer.

Top module: `sio_cfg_port`

## Requirements
- R1: After reset the port is locked (`cfg_open`=0), the logical-device select reads 0x00, `flash_ctl` is 0, and `flash_base` equals the parameter `FLASH_BASE_RST` (default 0x0820). Register 0x64 holds its high byte and register 0x65 its low byte.
- R2: The port opens in the clock edge that takes the fourth of four consecutive index-port writes 0x87, 0x01, 0x55, K. K is 0x55 when `BASE_PORT` is 0x2E and 0xAA when it is 0x4E. The other value of K leaves the port locked.
- R3: While the port is locked, an index-port byte that does not match the expected key byte sends the sequence back to its start. A mismatching byte of 0x87 counts as the first key byte, so 0x87, 0x87, 0x01, 0x55, K still opens the port.
- R4: While the port is locked, data-port writes change no register, and reads of either port return 0xFF.
- R5: While the port is open, an index-port write sets the register index, and an index-port read returns it.
- R6: While the port is open, register 0x20 reads 0x87 and register 0x21 reads 0x16 (chip ID 0x8716, high byte first).
- R7: Register 0x07 is the logical-device select and reads back what was written. Registers 0x64 and 0x65 are reachable only while the select is 7. With any other select they read 0x00 and ignore writes.
- R8: Register 0x24 is the flash control register. Bits 5:0 are writable, and bits 7:6 read 0. Bit 0 is suspend, bit 1 enables the top 128 KiB window and its legacy alias, bit 2 enables a second 128 KiB window, bit 3 enables a 448 KiB window, bit 4 enables host flash writes, and bit 5 selects the flash chip-select pin. `flash_ctl` shows bits 5:0 from the edge after the write.
- R9: A data-port write to register 0x02 with bit 1 set locks the port from the next cycle. A write with bit 1 clear changes nothing.
- R10: Reads of any address other than the two ports return 0xFF, and writes to such addresses have no effect.
- R11: `flash_base` shows {reg 0x64, reg 0x65} from the edge after a write to either register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | I/O address of the current access |
| io_wr | input | 1 | Write strobe, sampled at the clock edge |
| io_rd | input | 1 | Read strobe, read data is combinational |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data, 0xFF when not decoded |
| cfg_open | output | 1 | Configuration mode is open |
| flash_ctl | output | 6 | Flash window control bits 5:0 of register 0x24 |
| flash_base | output | 16 | Serial-flash controller base address |

## Verification
The assertions check the following on every cycle:
- The port opens only in the cycle after the final key byte reaches the index port.
- A locked port reads 0xFF and holds its control outputs.
- The exit write closes the port one cycle later.
- The chip-ID high byte is returned.
- `flash_ctl` takes each control write.

Only the bench scenarios can show the rest:
- The key rejection is checked with a sweep of every wrong second byte.
- The restart on a repeated first byte is checked by sending that sequence.
- The base-dependent fourth byte is checked on two instances with different base addresses.
- The device gating of the base registers is checked with the select at 0 and at 7.
- Register 0x24 is checked with all 256 values written and read back.

// File: rtl/sio_cfg_pkg.sv
package sio_cfg_pkg;
  localparam logic [7:0] RA_EXIT   = 8'h02;
  localparam logic [7:0] RA_LDN    = 8'h07;
  localparam logic [7:0] RA_ID_HI  = 8'h20;
  localparam logic [7:0] RA_ID_LO  = 8'h21;
  localparam logic [7:0] RA_FCTL   = 8'h24;
  localparam logic [7:0] RA_FB_HI  = 8'h64;
  localparam logic [7:0] RA_FB_LO  = 8'h65;
  localparam int         KEY_LEN   = 4;
  localparam int         STEP_W    = $clog2(KEY_LEN);
  localparam int         FCTL_W    = 6;
  localparam logic [7:0] IDLE_READ = 8'hFF;

  // Key byte expected at a given step; the last one depends on the base port.
  function automatic logic [7:0] key_byte(input logic [STEP_W-1:0] step,
                                          input logic [15:0] base);
    logic [7:0] k;
    case (step)
      2'd0:    k = 8'h87;
      2'd1:    k = 8'h01;
      2'd2:    k = 8'h55;
      default: k = (base == 16'h002E) ? 8'h55 : 8'hAA;
    endcase
    return k;
  endfunction

  // Next sequencer step after an index-port byte while locked.
  function automatic logic [STEP_W-1:0] key_next(input logic [STEP_W-1:0] step,
                                                 input logic [7:0] b,
                                                 input logic [15:0] base);
    logic [STEP_W-1:0] n;
    if (b == key_byte(step, base))
      n = (step == STEP_W'(KEY_LEN - 1)) ? '0 : step + 1'b1;
    else if (b == key_byte('0, base))
      n = STEP_W'(1);
    else
      n = '0;
    return n;
  endfunction

  // Control register write value after masking reserved bits.
  function automatic logic [7:0] fctl_mask(input logic [7:0] v);
    return v & 8'((1 << FCTL_W) - 1);
  endfunction
endpackage

// File: rtl/sio_port_dec.sv
module sio_port_dec #(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] BASE_PORT = 16'h002E
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              idx_sel,
  output logic              dat_sel
);
  localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(BASE_PORT);
  localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(BASE_PORT) + 1'b1;

  assign idx_sel = (addr == IDX_A);
  assign dat_sel = (addr == DAT_A);
endmodule

// File: rtl/sio_key_seq.sv
module sio_key_seq
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] BASE_PORT = 16'h002E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       key_wr,
  input  logic [7:0] key_data,
  output logic       key_done
);
  logic [STEP_W-1:0] step_q;

  assign key_done = key_wr && (step_q == STEP_W'(KEY_LEN - 1)) &&
                    (key_data == key_byte(step_q, BASE_PORT));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      step_q <= '0;
    else if (key_wr) step_q <= key_next(step_q, key_data, BASE_PORT);
  end
endmodule

// File: rtl/sio_reg_bank.sv
module sio_reg_bank
  import sio_cfg_pkg::*;
#(
  parameter logic [15:0] CHIP_ID        = 16'h8716,
  parameter logic [7:0]  FLASH_LDN      = 8'h07,
  parameter logic [15:0] FLASH_BASE_RST = 16'h0820
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        idx_wr,
  input  logic        dat_wr,
  input  logic [7:0]  wdata,
  output logic [7:0]  index,
  output logic [7:0]  rd_reg,
  output logic        exit_req,
  output logic [7:0]  fctl,
  output logic [15:0] fbase
);
  logic [7:0] ldn_q, fctl_q, fb_hi_q, fb_lo_q, index_q;
  logic       ldn_is_flash;

  assign ldn_is_flash = (ldn_q == FLASH_LDN);
  assign exit_req     = dat_wr && (index_q == RA_EXIT) && wdata[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      index_q <= 8'h00;
      ldn_q   <= 8'h00;
      fctl_q  <= 8'h00;
      fb_hi_q <= FLASH_BASE_RST[15:8];
      fb_lo_q <= FLASH_BASE_RST[7:0];
    end else begin
      if (idx_wr) index_q <= wdata;
      if (dat_wr) begin
        case (index_q)
          RA_LDN:   ldn_q  <= wdata;
          RA_FCTL:  fctl_q <= fctl_mask(wdata);
          RA_FB_HI: if (ldn_is_flash) fb_hi_q <= wdata;
          RA_FB_LO: if (ldn_is_flash) fb_lo_q <= wdata;
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    case (index_q)
      RA_LDN:   rd_reg = ldn_q;
      RA_ID_HI: rd_reg = CHIP_ID[15:8];
      RA_ID_LO: rd_reg = CHIP_ID[7:0];
      RA_FCTL:  rd_reg = fctl_q;
      RA_FB_HI: rd_reg = ldn_is_flash ? fb_hi_q : 8'h00;
      RA_FB_LO: rd_reg = ldn_is_flash ? fb_lo_q : 8'h00;
      default:  rd_reg = 8'h00;
    endcase
  end

  assign index = index_q;
  assign fctl  = fctl_q;
  assign fbase = {fb_hi_q, fb_lo_q};
endmodule

// File: rtl/sio_cfg_port.sv
module sio_cfg_port
  import sio_cfg_pkg::*;
#(
  parameter int          ADDR_W         = 16,
  parameter logic [15:0] BASE_PORT      = 16'h002E,
  parameter logic [15:0] CHIP_ID        = 16'h8716,
  parameter logic [7:0]  FLASH_LDN      = 8'h07,
  parameter logic [15:0] FLASH_BASE_RST = 16'h0820
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic              io_rd,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic              cfg_open,
  output logic [FCTL_W-1:0] flash_ctl,
  output logic [15:0]       flash_base
);
  // Named internal events, brought out for the checker.
  logic       idx_sel, dat_sel;
  logic       key_wr, key_done;
  logic       idx_wr, dat_wr, exit_req;
  logic [7:0] cur_index, rd_reg, fctl_full;
  logic       open_q;

  sio_port_dec #(.ADDR_W(ADDR_W), .BASE_PORT(BASE_PORT)) u_dec (
    .addr(io_addr), .idx_sel(idx_sel), .dat_sel(dat_sel));

  assign key_wr = io_wr && idx_sel && !open_q;
  assign idx_wr = io_wr && idx_sel && open_q;
  assign dat_wr = io_wr && dat_sel && open_q;

  sio_key_seq #(.BASE_PORT(BASE_PORT)) u_key (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(io_wdata),
    .key_done(key_done));

  sio_reg_bank #(.CHIP_ID(CHIP_ID), .FLASH_LDN(FLASH_LDN),
                 .FLASH_BASE_RST(FLASH_BASE_RST)) u_regs (
    .clk(clk), .rst_n(rst_n), .idx_wr(idx_wr), .dat_wr(dat_wr),
    .wdata(io_wdata), .index(cur_index), .rd_reg(rd_reg),
    .exit_req(exit_req), .fctl(fctl_full), .fbase(flash_base));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        open_q <= 1'b0;
    else if (key_done) open_q <= 1'b1;
    else if (exit_req) open_q <= 1'b0;
  end

  always_comb begin
    io_rdata = IDLE_READ;
    if (io_rd && open_q) begin
      if (idx_sel)      io_rdata = cur_index;
      else if (dat_sel) io_rdata = rd_reg;
    end
  end

  assign cfg_open  = open_q;
  assign flash_ctl = fctl_full[FCTL_W-1:0];
endmodule

// File: rtl/sio_cfg_port_chk.sv
module sio_cfg_port_chk
  import sio_cfg_pkg::*;
#(
  parameter int          ADDR_W    = 16,
  parameter logic [15:0] BASE_PORT = 16'h002E,
  parameter logic [15:0] CHIP_ID   = 16'h8716
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] io_addr,
  input logic              io_wr,
  input logic              io_rd,
  input logic [7:0]        io_wdata,
  input logic [7:0]        io_rdata,
  input logic              cfg_open,
  input logic [FCTL_W-1:0] flash_ctl,
  input logic [15:0]       flash_base,
  input logic [7:0]        cur_index
);
  localparam logic [ADDR_W-1:0] IDX_A = ADDR_W'(BASE_PORT);
  localparam logic [ADDR_W-1:0] DAT_A = ADDR_W'(BASE_PORT) + 1'b1;
  localparam logic [7:0]        LAST_KEY = key_byte(STEP_W'(KEY_LEN - 1), BASE_PORT);

  p_open_after_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(io_wr && io_addr == IDX_A && io_wdata == LAST_KEY));

  p_locked_reads_ff_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && io_rd) |-> io_rdata == 8'hFF);

  p_locked_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_open |=> ($stable(flash_ctl) && $stable(flash_base)));

  p_chip_id_hi_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && io_rd && io_addr == DAT_A && cur_index == 8'h20)
      |-> io_rdata == CHIP_ID[15:8]);

  p_ctl_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && io_wr && io_addr == DAT_A && cur_index == 8'h24)
      |=> flash_ctl == $past(io_wdata[FCTL_W-1:0]));

  p_exit_closes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && io_wr && io_addr == DAT_A && cur_index == 8'h02 && io_wdata[1])
      |=> !cfg_open);

  p_foreign_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr != IDX_A && io_addr != DAT_A) |-> io_rdata == 8'hFF);
endmodule

bind sio_cfg_port sio_cfg_port_chk #(.ADDR_W(ADDR_W), .BASE_PORT(BASE_PORT),
                                     .CHIP_ID(CHIP_ID)) u_chk (
  .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
  .io_wdata(io_wdata), .io_rdata(io_rdata), .cfg_open(cfg_open),
  .flash_ctl(flash_ctl), .flash_base(flash_base), .cur_index(cur_index));

// File: tb/sim_sio_cfg_port.sv
`timescale 1ns/100ps
module sim_sio_cfg_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic        io_wr = 1'b0, io_rd = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  rd0, rd1;
  logic        open0, open1;
  logic [5:0]  ctl0, ctl1;
  logic [15:0] fb0, fb1;
  int          vectors = 0, misses = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  sio_cfg_port u0 (.clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(rd0), .cfg_open(open0),
    .flash_ctl(ctl0), .flash_base(fb0));

  sio_cfg_port #(.BASE_PORT(16'h004E)) u1 (.clk(clk), .rst_n(rst_n),
    .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata),
    .io_rdata(rd1), .cfg_open(open1), .flash_ctl(ctl1), .flash_base(fb1));

  task automatic chk(input string tag, input int got, input int exp);
    vectors++;
    if (got != exp) begin
      misses++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_addr = a; io_wdata = d; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d0, output logic [7:0] d1);
    @(negedge clk); io_addr = a; io_rd = 1'b1;
    #1; d0 = rd0; d1 = rd1; io_rd = 1'b0;
  endtask

  task automatic key(input logic [15:0] a, input logic [7:0] k1, input logic [7:0] k2,
                     input logic [7:0] k3, input logic [7:0] k4);
    wr(a, k1); wr(a, k2); wr(a, k3); wr(a, k4);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    misses++;
    $display("FAIL watchdog: got 0x0 expected 0x1");
    summary();
  end

  initial begin
    logic [7:0] a, b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    @(negedge clk);
    chk("R1 open", open0, 0);
    chk("R1 ctl", ctl0, 0);
    chk("R1 base", fb0, 16'h0820);
    // R4 locked: data write ignored, reads 0xFF
    wr(16'h002F, 8'hFF);
    chk("R4 locked write ctl", ctl0, 0);
    chk("R4 locked write base", fb0, 16'h0820);
    rd(16'h002F, a, b); chk("R4 locked data read", a, 8'hFF);
    rd(16'h002E, a, b); chk("R4 locked index read", a, 8'hFF);
    // R2 unlock u0 with base 0x2E key
    key(16'h002E, 8'h87, 8'h01, 8'h55, 8'h55);
    chk("R2 u0 opens", open0, 1);
    chk("R10 u1 untouched", open1, 0);
    // R5 index readback, R6 chip id
    wr(16'h002E, 8'h20);
    rd(16'h002E, a, b); chk("R5 index readback", a, 8'h20);
    rd(16'h002F, a, b); chk("R6 id high", a, 8'h87);
    wr(16'h002E, 8'h21);
    rd(16'h002F, a, b); chk("R6 id low", a, 8'h16);
    // R7 device gating
    wr(16'h002E, 8'h07);
    rd(16'h002F, a, b); chk("R1 ldn reset", a, 0);
    wr(16'h002E, 8'h64);
    rd(16'h002F, a, b); chk("R7 base hi hidden", a, 0);
    wr(16'h002F, 8'h12);
    chk("R7 write ignored", fb0, 16'h0820);
    wr(16'h002E, 8'h07); wr(16'h002F, 8'h07);
    rd(16'h002F, a, b); chk("R7 ldn readback", a, 7);
    wr(16'h002E, 8'h64);
    rd(16'h002F, a, b); chk("R1 base hi reset", a, 8'h08);
    wr(16'h002F, 8'hAB);
    chk("R11 base hi out", fb0, 16'hAB20);
    wr(16'h002E, 8'h65);
    rd(16'h002F, a, b); chk("R1 base lo reset", a, 8'h20);
    wr(16'h002F, 8'hCD);
    chk("R11 base out", fb0, 16'hABCD);
    rd(16'h002F, a, b); chk("R7 base lo readback", a, 8'hCD);
    // R8 sweep of control register
    wr(16'h002E, 8'h24);
    for (int v = 0; v < 256; v++) begin
      wr(16'h002F, 8'(v));
      chk("R8 ctl out", ctl0, v & 8'h3F);
      rd(16'h002F, a, b); chk("R8 ctl readback", a, v & 8'h3F);
    end
    wr(16'h002F, 8'h2A);
    // R10 foreign address
    rd(16'h0080, a, b); chk("R10 foreign u0", a, 8'hFF); chk("R10 foreign u1", b, 8'hFF);
    wr(16'h0080, 8'h00);
    chk("R10 foreign write", ctl0, 6'h2A);
    // R9 exit
    wr(16'h002E, 8'h02); wr(16'h002F, 8'h01);
    chk("R9 bit1 clear stays open", open0, 1);
    wr(16'h002F, 8'h02);
    chk("R9 exit", open0, 0);
    rd(16'h002F, a, b); chk("R4 read after exit", a, 8'hFF);
    chk("R4 ctl kept", ctl0, 6'h2A);
    // R3 sweep of wrong second byte
    for (int v = 0; v < 256; v++) begin
      if (v != 1) begin
        key(16'h002E, 8'h87, 8'(v), 8'h55, 8'h55);
        chk("R3 wrong byte stays locked", open0, 0);
      end
    end
    // R3 repeated first byte restarts
    wr(16'h002E, 8'h87);
    key(16'h002E, 8'h87, 8'h01, 8'h55, 8'h55);
    chk("R3 restart on 0x87", open0, 1);
    wr(16'h002E, 8'h02); wr(16'h002F, 8'h02);
    chk("R9 exit again", open0, 0);
    // R2 base-dependent last byte
    key(16'h002E, 8'h87, 8'h01, 8'h55, 8'hAA);
    chk("R2 u0 rejects 0xAA", open0, 0);
    key(16'h004E, 8'h87, 8'h01, 8'h55, 8'h55);
    chk("R2 u1 rejects 0x55", open1, 0);
    key(16'h004E, 8'h87, 8'h01, 8'h55, 8'hAA);
    chk("R2 u1 opens", open1, 1);
    wr(16'h004E, 8'h20);
    rd(16'h004F, a, b); chk("R6 u1 id high", b, 8'h87);
    chk("R10 u0 still locked", open0, 0);
    summary();
  end
endmodule